// File: doc/BRIEF.md
# Interrupt Distributor Register File

The block collects a parameterised set of interrupt lines (32, 64 or 96) and decides, for every CPU it serves, which pending and enabled line that CPU should take next. Software drives it through a 32-bit word bus with byte enables. Through this bus it sets and clears each line's enable and pending state in separate set banks and clear banks. It also programs a per-line priority byte, a per-line CPU routing byte and a per-line edge/level choice. A global switch lets software stop all forwarding at once.

Each CPU output is a plain level, not a stream. It holds the winning line's ID and priority for as long as that line stays eligible, and it changes on its own when the line state changes. Nothing consumes or acknowledges it, so there is no back-pressure. The bus is a simple strobe interface with no stall. A read strobe returns its word on `bus_rdata` after the next clock edge, and a write strobe takes effect at that edge.

Line IDs 0 to 15 are software-generated lines and are always edge-triggered. IDs 16 to 31 are private peripheral lines. IDs 32 and up are shared peripheral lines. In the register arrays below, line `i` occupies bit `i%32` of bank word `i/32`, byte lane `i%4` of byte word `i/4`, and bits `2*(i%16)+1 : 2*(i%16)` of configuration word `i/16`.

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the control word at offset 0x000 is the global forward switch and resets to 0. While it is 0, every CPU output shows no interrupt: `cpu_valid` = 0, ID 1023 and priority 0xFF.
- R2: The read-only word at 0x004 returns NUM_LINES/32-1 in bits 4:0 and NUM_CPUS-1 in bits 7:5. All other bits are 0.
- R3: At 0x100 (set) and 0x180 (clear), writing a 1 to a line's bit sets or clears its enable. A 0 bit, or a bit whose byte enable is low, has no effect. Both banks read back the enable state. Clearing an enable leaves the pending state as it was.
- R4: At 0x200 (set) and 0x280 (clear), writing a 1 to a line's bit sets or clears its pending latch. Both banks read back the pending state.
- R5: The priority byte of each line starts at 0x400. Only bits 7:4 are stored, and bits 3:0 read as 0. A lower value wins, and a byte lane is written only when its byte enable is high.
- R6: The routing byte of each line starts at 0x800. Bit c routes the line to CPU c. Bits at or above NUM_CPUS read as 0.
- R7: The configuration words start at 0xC00. Bit 2k+1 is 1 for edge and 0 for level, and bit 2k reads 0. Lines 0 to 15 always read as edge, and writes to them are ignored. Other lines reset to level.
- R8: An edge line becomes pending on a rising edge of its input and stays pending after the input falls, until a clear-pending write.
- R9: A level line is pending while its input is high, whatever clear-pending writes occur. Once the input is low, it is pending only if a set-pending write latched it.
- R10: Each CPU takes the eligible line (pending, enabled, routed to it, global switch on) with the lowest priority value. On a tie, the lower ID wins. With no eligible line, the output is ID 1023 and priority 0xFF.
- R11: Reads of unimplemented or misaligned offsets, including array slots beyond NUM_LINES, return 0, and writes to them change nothing.
- R12: Read data appears one edge after the read strobe. An input change shows in the pending state one edge later. A state change shows on the CPU outputs one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data, valid one edge after `bus_rd` |
| irq_in | input | NUM_LINES | Interrupt input lines |
| cpu_valid | output | NUM_CPUS | An eligible line exists for CPU c |
| cpu_id | output | NUM_CPUS*10 | Winning line ID for CPU c at bits 10c+9:10c |
| cpu_prio | output | NUM_CPUS*8 | Winning priority for CPU c at bits 8c+7:8c |

## Verification
Read data is due on the falling edge right after the clock edge that samples the read strobe. The monitor compares each queued expected word exactly there. A write or a pending change reaches the CPU outputs one edge after it lands, and an input change takes two edges. The bench therefore checks outputs on a counted falling edge: one cycle after a write, and two cycles after an input change. The intermediate cycle is also sampled once, to confirm that the result does not arrive early.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ADDR_W           = 12;
  localparam int unsigned ID_W             = 10;
  localparam int unsigned PRIO_BITS        = 4;
  localparam int unsigned FIXED_EDGE_LINES = 16;
  localparam logic [ID_W-1:0] ID_NONE      = 10'd1023;
  localparam logic [7:0]      PRIO_IDLE    = 8'hFF;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CTL,
    RG_TYPE,
    RG_EN_SET,
    RG_EN_CLR,
    RG_PD_SET,
    RG_PD_CLR,
    RG_PRIO,
    RG_TGT,
    RG_CFG
  } region_e;
endpackage

// File: rtl/irqd_bus_decode.sv
module irqd_bus_decode
  import irqd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [4:0]        bit_word,
  output logic [7:0]        byte_word,
  output logic [5:0]        cfg_word
);
  always_comb begin
    bit_word  = addr[6:2];
    byte_word = addr[9:2];
    cfg_word  = addr[7:2];
    region    = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      casez (addr[11:7])
        5'b00000: begin
          if (addr[6:2] == 5'd0)      region = RG_CTL;
          else if (addr[6:2] == 5'd1) region = RG_TYPE;
          else                        region = RG_NONE;
        end
        5'b00010: region = RG_EN_SET;
        5'b00011: region = RG_EN_CLR;
        5'b00100: region = RG_PD_SET;
        5'b00101: region = RG_PD_CLR;
        5'b01???: region = RG_PRIO;
        5'b10???: region = RG_TGT;
        5'b1100?: region = RG_CFG;
        default:  region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqd_line.sv
module irqd_line
  import irqd_pkg::*;
#(
  parameter int unsigned LINE_ID  = 0,
  parameter int unsigned NUM_CPUS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_in,
  input  logic                 en_set,
  input  logic                 en_clr,
  input  logic                 pd_set,
  input  logic                 pd_clr,
  input  logic                 prio_we,
  input  logic [PRIO_BITS-1:0] prio_d,
  input  logic                 tgt_we,
  input  logic [NUM_CPUS-1:0]  tgt_d,
  input  logic                 cfg_we,
  input  logic                 cfg_edge,
  output logic                 enabled,
  output logic                 pending,
  output logic [PRIO_BITS-1:0] prio,
  output logic [NUM_CPUS-1:0]  target,
  output logic                 is_edge
);
  localparam logic FIXED = (LINE_ID < FIXED_EDGE_LINES);

  logic irq_q;
  logic latch_q;
  logic edge_q;
  logic rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      latch_q <= 1'b0;
      edge_q  <= FIXED;
      enabled <= 1'b0;
      prio    <= '0;
      target  <= '0;
    end else begin
      irq_q <= irq_in;
      if (pd_set || (edge_q && rise)) latch_q <= 1'b1;
      else if (pd_clr)                latch_q <= 1'b0;
      if (cfg_we) edge_q <= FIXED | cfg_edge;
      if (en_set)      enabled <= 1'b1;
      else if (en_clr) enabled <= 1'b0;
      if (prio_we) prio <= prio_d;
      if (tgt_we)  target <= tgt_d;
    end
  end

  assign pending = latch_q | (~edge_q & irq_q);
  assign is_edge = edge_q;

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && pending && !pd_clr) |=> pending); // R8
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_edge && irq_in && !cfg_we) |=> pending); // R9
  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set) |=> !enabled); // R3
endmodule

// File: rtl/irqd_select.sv
module irqd_select
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_LINES-1:0]                 eligible,
  input  logic [NUM_LINES-1:0][PRIO_BITS-1:0]  line_prio,
  output logic                                 out_valid,
  output logic [ID_W-1:0]                      out_id,
  output logic [7:0]                           out_prio
);
  logic                 best_found;
  logic [ID_W-1:0]      best_id;
  logic [PRIO_BITS-1:0] best_p;

  // Ascending scan with strict compare: lowest ID keeps a tie.
  always_comb begin
    best_found = 1'b0;
    best_id    = ID_NONE;
    best_p     = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (eligible[i] && (!best_found || (line_prio[i] < best_p))) begin
        best_found = 1'b1;
        best_id    = ID_W'(i);
        best_p     = line_prio[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_id    <= ID_NONE;
      out_prio  <= PRIO_IDLE;
    end else begin
      out_valid <= best_found;
      out_id    <= best_found ? best_id : ID_NONE;
      out_prio  <= best_found ? {best_p, 4'b0000} : PRIO_IDLE;
    end
  end

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id < ID_W'(NUM_LINES))); // R10
  AST_EMPTY_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible == '0) |=> (!out_valid && out_id == ID_NONE)); // R10
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic [3:0]               bus_be,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_LINES-1:0]     irq_in,
  output logic [NUM_CPUS-1:0]      cpu_valid,
  output logic [NUM_CPUS*ID_W-1:0] cpu_id,
  output logic [NUM_CPUS*8-1:0]    cpu_prio
);
  localparam logic [4:0] LINE_CODE = 5'(NUM_LINES / 32 - 1);
  localparam logic [2:0] CPU_CODE  = 3'(NUM_CPUS - 1);

  region_e    region;
  logic [4:0] bit_word;
  logic [7:0] byte_word;
  logic [5:0] cfg_word;
  logic       glob_en;
  logic [31:0] rd_word;

  logic [NUM_LINES-1:0]                en_vec;
  logic [NUM_LINES-1:0]                pend_vec;
  logic [NUM_LINES-1:0]                edge_vec;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio_arr;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0]  tgt_arr;

  irqd_bus_decode u_decode (
    .addr      (bus_addr),
    .region    (region),
    .bit_word  (bit_word),
    .byte_word (byte_word),
    .cfg_word  (cfg_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_en <= 1'b0;
    else if (bus_wr && region == RG_CTL && bus_be[0]) glob_en <= bus_wdata[0];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [4:0] BW   = 5'(i / 32);
    localparam int unsigned BB  = i % 32;
    localparam logic [7:0] PW   = 8'(i / 4);
    localparam int unsigned PL  = i % 4;
    localparam logic [5:0] CW   = 6'(i / 16);
    localparam int unsigned CB  = 2 * (i % 16) + 1;

    logic bit_hit;
    logic byte_hit;
    logic cfg_hit;

    assign bit_hit  = bus_wr && (bit_word == BW) && bus_be[BB/8] && bus_wdata[BB];
    assign byte_hit = bus_wr && (byte_word == PW) && bus_be[PL];
    assign cfg_hit  = bus_wr && (region == RG_CFG) && (cfg_word == CW) && bus_be[CB/8];

    irqd_line #(
      .LINE_ID  (i),
      .NUM_CPUS (NUM_CPUS)
    ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in[i]),
      .en_set   (bit_hit && region == RG_EN_SET),
      .en_clr   (bit_hit && region == RG_EN_CLR),
      .pd_set   (bit_hit && region == RG_PD_SET),
      .pd_clr   (bit_hit && region == RG_PD_CLR),
      .prio_we  (byte_hit && region == RG_PRIO),
      .prio_d   (bus_wdata[PL*8+4 +: PRIO_BITS]),
      .tgt_we   (byte_hit && region == RG_TGT),
      .tgt_d    (bus_wdata[PL*8 +: NUM_CPUS]),
      .cfg_we   (cfg_hit),
      .cfg_edge (bus_wdata[CB]),
      .enabled  (en_vec[i]),
      .pending  (pend_vec[i]),
      .prio     (prio_arr[i]),
      .target   (tgt_arr[i]),
      .is_edge  (edge_vec[i])
    );
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_LINES-1:0] elig;
    always_comb begin
      for (int i = 0; i < NUM_LINES; i++)
        elig[i] = glob_en & en_vec[i] & pend_vec[i] & tgt_arr[i][c];
    end

    irqd_select #(
      .NUM_LINES (NUM_LINES)
    ) u_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .eligible  (elig),
      .line_prio (prio_arr),
      .out_valid (cpu_valid[c]),
      .out_id    (cpu_id[c*ID_W +: ID_W]),
      .out_prio  (cpu_prio[c*8 +: 8])
    );
  end

  always_comb begin
    rd_word = '0;
    case (region)
      RG_CTL:  rd_word[0] = glob_en;
      RG_TYPE: rd_word[7:0] = {CPU_CODE, LINE_CODE};
      default: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if ((region == RG_EN_SET || region == RG_EN_CLR) && bit_word == 5'(i / 32))
            rd_word[i % 32] = en_vec[i];
          if ((region == RG_PD_SET || region == RG_PD_CLR) && bit_word == 5'(i / 32))
            rd_word[i % 32] = pend_vec[i];
          if (region == RG_PRIO && byte_word == 8'(i / 4))
            rd_word[(i % 4)*8 +: 8] = {prio_arr[i], 4'b0000};
          if (region == RG_TGT && byte_word == 8'(i / 4))
            rd_word[(i % 4)*8 +: 8] = 8'(tgt_arr[i]);
          if (region == RG_CFG && cfg_word == 6'(i / 16))
            rd_word[2*(i % 16)+1] = edge_vec[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> (cpu_valid == '0)); // R1
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
  localparam int NL = 64;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NC-1:0] cpu_valid;
  logic [NC*10-1:0] cpu_id;
  logic [NC*8-1:0]  cpu_prio;

  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #4 clk = ~clk;

  irq_distributor #(.NUM_LINES(NL), .NUM_CPUS(NC)) i_irq_distributor (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_valid(cpu_valid),
    .cpu_id(cpu_id), .cpu_prio(cpu_prio)
  );

  // Monitor: read data is due on the falling edge after the sampling edge.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      rd_item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read data %h with no expected item", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: read %h got %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_out(input int c, input logic v, input logic [9:0] id,
                           input logic [7:0] p, input string tag);
    checks++;
    if (cpu_valid[c] !== v || cpu_id[c*10 +: 10] !== id || cpu_prio[c*8 +: 8] !== p) begin
      errors++;
      $display("FAIL %s: cpu%0d got v=%b id=%0d p=%h expected v=%b id=%0d p=%h",
               tag, c, cpu_valid[c], cpu_id[c*10 +: 10], cpu_prio[c*8 +: 8], v, id, p);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);

    check_out(0, 1'b0, 10'd1023, 8'hFF, "R1 reset cpu0");
    check_out(1, 1'b0, 10'd1023, 8'hFF, "R1 reset cpu1");
    bus_read(12'h000, 32'h0, "R1 control reset");
    bus_read(12'h004, 32'h21, "R2 type word");

    // R11 unimplemented and out-of-range slots
    bus_write(12'h040, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'h040, 32'h0, "R11 hole write ignored");
    bus_read(12'hF00, 32'h0, "R11 high hole");
    bus_read(12'h401, 32'h0, "R11 misaligned");
    bus_write(12'h440, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'h440, 32'h0, "R11 priority beyond lines");

    // R5 priority bytes and byte enables
    bus_write(12'h428, 32'h0000_00A5, 4'b0001);
    bus_read(12'h428, 32'h0000_00A0, "R5 low nibble zero");
    bus_write(12'h428, 32'hFFFF_FF00, 4'b1110);
    bus_read(12'h428, 32'hF0F0_F0A0, "R5 byte lanes");

    // R6 routing
    bus_write(12'h828, 32'h0000_00FF, 4'b0001);
    bus_read(12'h828, 32'h0000_0003, "R6 unused cpu bits zero");
    bus_write(12'h828, 32'h0000_0001, 4'b0001);
    bus_read(12'h828, 32'h0000_0001, "R6 route cpu0");

    // R3 enable banks
    bus_write(12'h104, 32'h0000_0100, 4'b0010);
    bus_read(12'h104, 32'h0000_0100, "R3 set bank readback");
    bus_read(12'h184, 32'h0000_0100, "R3 clear bank readback");
    bus_write(12'h104, 32'h0000_0001, 4'b1110);
    bus_read(12'h104, 32'h0000_0100, "R3 masked lane ignored");
    bus_write(12'h184, 32'h0000_0000, 4'hF);
    bus_read(12'h104, 32'h0000_0100, "R3 zero write no effect");

    // R7 configuration
    bus_write(12'hC08, 32'h0002_0000, 4'hF);
    bus_read(12'hC08, 32'h0002_0000, "R7 line 40 edge");
    bus_write(12'hC00, 32'h0000_0000, 4'hF);
    bus_read(12'hC00, 32'hAAAA_AAAA, "R7 fixed edge lines");
    bus_write(12'hC10, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'hC10, 32'h0, "R11 config beyond lines");

    bus_write(12'h000, 32'h1, 4'hF);
    bus_read(12'h000, 32'h1, "R1 control set");

    // R8 / R12 edge pulse on line 40
    @(negedge clk); irq_in[40] = 1'b1;
    wait_cycles(1);
    check_out(0, 1'b0, 10'd1023, 8'hFF, "R12 not early");
    irq_in[40] = 1'b0;
    wait_cycles(1);
    check_out(0, 1'b1, 10'd40, 8'hA0, "R8 R12 edge taken");
    check_out(1, 1'b0, 10'd1023, 8'hFF, "R6 cpu1 not routed");
    wait_cycles(3);
    check_out(0, 1'b1, 10'd40, 8'hA0, "R8 sticky after drop");
    bus_read(12'h204, 32'h0000_0100, "R4 pending readback");

    // R4 clear and set pending
    bus_write(12'h284, 32'h0000_0100, 4'b0010);
    wait_cycles(1);
    check_out(0, 1'b0, 10'd1023, 8'hFF, "R4 cleared");
    bus_read(12'h284, 32'h0, "R4 clear bank readback");
    bus_write(12'h204, 32'h0000_0100, 4'b0010);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd40, 8'hA0, "R4 set pending");

    // R1 gate
    bus_write(12'h000, 32'h0, 4'hF);
    wait_cycles(1);
    check_out(0, 1'b0, 10'd1023, 8'hFF, "R1 switch off");
    bus_write(12'h000, 32'h1, 4'hF);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd40, 8'hA0, "R1 switch on");

    // R10 tie: line 33 level, same priority
    bus_write(12'h420, 32'h0000_A000, 4'b0010);
    bus_write(12'h820, 32'h0000_0100, 4'b0010);
    bus_write(12'h104, 32'h0000_0002, 4'b0001);
    @(negedge clk); irq_in[33] = 1'b1;
    wait_cycles(2);
    check_out(0, 1'b1, 10'd33, 8'hA0, "R10 tie lower id");

    // R9 clear while high
    bus_write(12'h284, 32'h0000_0002, 4'b0001);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd33, 8'hA0, "R9 clear while high");
    bus_read(12'h204, 32'h0000_0102, "R9 level pending shown");

    // R5 lower value wins: line 35
    bus_write(12'h420, 32'h3000_0000, 4'b1000);
    bus_write(12'h820, 32'h0100_0000, 4'b1000);
    bus_write(12'h104, 32'h0000_0008, 4'b0001);
    bus_write(12'h204, 32'h0000_0008, 4'b0001);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd35, 8'h30, "R5 lower value wins");
    bus_write(12'h284, 32'h0000_0008, 4'b0001);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd33, 8'hA0, "R4 clear line 35");

    // R9 drop
    irq_in[33] = 1'b0;
    wait_cycles(2);
    check_out(0, 1'b1, 10'd40, 8'hA0, "R9 drop releases");
    bus_read(12'h204, 32'h0000_0100, "R9 pending after drop");
    bus_write(12'h204, 32'h0000_0002, 4'b0001);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd33, 8'hA0, "R9 latched level");
    bus_write(12'h284, 32'h0000_0002, 4'b0001);
    wait_cycles(1);
    check_out(0, 1'b1, 10'd40, 8'hA0, "R9 latch cleared");

    // R3 clear enable
    bus_write(12'h184, 32'h0000_0100, 4'b0010);
    wait_cycles(1);
    check_out(0, 1'b0, 10'd1023, 8'hFF, "R3 disabled none eligible R10");
    bus_read(12'h104, 32'h0000_000A, "R3 enables left");
    bus_read(12'h204, 32'h0000_0100, "R3 pending kept");

    // R6 / R7 low lines on cpu1
    bus_write(12'h404, 32'h0000_1000, 4'b0010);
    bus_write(12'h804, 32'h0000_0200, 4'b0010);
    bus_write(12'h100, 32'h0000_0020, 4'b0001);
    bus_write(12'h200, 32'h0000_0020, 4'b0001);
    wait_cycles(1);
    check_out(1, 1'b1, 10'd5, 8'h10, "R6 cpu1 routed");
    check_out(0, 1'b0, 10'd1023, 8'hFF, "R6 cpu0 not routed");
    bus_write(12'h804, 32'h0200_0000, 4'b1000);
    bus_write(12'h100, 32'h0000_0080, 4'b0001);
    @(negedge clk); irq_in[7] = 1'b1;
    wait_cycles(1);
    irq_in[7] = 1'b0;
    wait_cycles(1);
    check_out(1, 1'b1, 10'd7, 8'h00, "R7 fixed edge pulse");
    wait_cycles(2);
    check_out(1, 1'b1, 10'd7, 8'h00, "R7 fixed edge sticky");

    wait_cycles(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads never returned, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule